// File: doc/BRIEF.md
# Keyed Reset Controller Mode Logic

This block owns the mode register of a reset controller and the user-reset behaviour that register governs. Software reaches it over a simple single-cycle register bus. A mode write lands only when the top byte of the write data carries the password 0xA5 and the system controller's write-protect input is low. Every other write is dropped whole.

The active-low reset pin is brought through a two-flop synchronizer. A low level seen after the synchronizer always sets a user-reset status flag, and reading the status register clears that flag. When user reset is enabled, the same low level drives the external reset output low for a programmed number of clock cycles. That number grows as a power of two of a 4-bit length field. When user reset is disabled, the pin event can raise an interrupt instead.

The whole block runs on the slow clock. The synchronizer latency comes on top of the programmed pulse length.

Top module: `keyed_rst_mode`

## Requirements
- R1: After reset, the mode register at offset 0x08 reads 0x00000001, the status register at offset 0x04 reads 0, ext_rst_n is 1 and irq is 0.
- R2: A write to offset 0x08 whose bits 31:24 are not 0xA5 leaves the register unchanged. Bits 31:24 always read as 0.
- R3: While wp_en is 1, a write to offset 0x08 has no effect, even when the password is correct.
- R4: Writing 0xA5FFFFFF leaves the register reading 0x00000F11. Only bit 0 (user reset enable), bit 4 (interrupt enable) and bits 11:8 (length L) can be written. All other bits read as 0.
- R5: With bit 0 = 1, a pin_n low level sampled at one rising edge drives ext_rst_n low from the second rising edge after that sample. ext_rst_n then stays low for exactly 2^(L+1) cycles.
- R6: With bit 0 = 0, a low level on pin_n never drives ext_rst_n low.
- R7: A low level on pin_n, after synchronization, sets status bit 0 whatever the value of mode bit 0. A bus read of offset 0x04 returns the flag and clears it. A later read returns 0.
- R8: irq is 1 exactly when status bit 0 is 1, mode bit 4 is 1 and mode bit 0 is 0.
- R9: A new trigger while ext_rst_n is low restarts the count. ext_rst_n then stays low for 2^(L+1) cycles counted from the latest trigger. A pin held low keeps retriggering, so ext_rst_n stays low for as long as the pin is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock for the whole block |
| rst_n | input | 1 | Active-low block reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wp_en | input | 1 | Write protect from the system controller |
| pin_n | input | 1 | Asynchronous active-low reset pin |
| ext_rst_n | output | 1 | Active-low external reset pulse |
| irq | output | 1 | User-reset interrupt |

## Verification
A wrongly accepted or wrongly dropped write shows on the next read of offset 0x08. It also changes the length of the next reset pulse.

A counter that loads one value too few or too many shows as an ext_rst_n low phase one cycle off. A pulse-length error at any L is therefore visible within 2^(L+1) cycles of the trigger. The sweep covers every L, so every field value of the length decode is exercised.

A wrong synchronizer depth shifts the pulse start by one cycle relative to the pin. A status flag that is not cleared shows on the second status read and on irq.

// File: rtl/keyed_rst_pkg.sv
package keyed_rst_pkg;
  localparam int unsigned OFS_STATUS = 32'h04;
  localparam int unsigned OFS_MODE   = 32'h08;
  localparam logic [7:0]  WR_KEY     = 8'hA5;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_IEN    = 4;
  localparam int unsigned LEN_LSB    = 8;
endpackage

// File: rtl/krm_sync.sv
module krm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/krm_mode_reg.sv
module krm_mode_reg
  import keyed_rst_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [31:0]      wdata,
  input  logic             wp_en,
  output logic             ursten,
  output logic             urstien,
  output logic [LEN_W-1:0] len
);
  logic key_ok;
  logic wr_ok;

  assign key_ok = (wdata[31:24] == WR_KEY);
  assign wr_ok  = wr_stb && key_ok && !wp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ursten  <= 1'b1;
      urstien <= 1'b0;
      len     <= '0;
    end else if (wr_ok) begin
      ursten  <= wdata[BIT_EN];
      urstien <= wdata[BIT_IEN];
      len     <= wdata[LEN_LSB +: LEN_W];
    end
  end

  // R2: a bad password leaves every field untouched
  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !key_ok) |=> ($stable(ursten) && $stable(urstien) && $stable(len)));

  // R3: write protect blocks the write
  p_wprot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wp_en) |=> ($stable(ursten) && $stable(urstien) && $stable(len)));
endmodule

// File: rtl/krm_pulse.sv
module krm_pulse #(
  parameter int LEN_W = 4,
  localparam int CNT_W = (1 << LEN_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic [LEN_W-1:0] len,
  output logic             ext_rst_n
);
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] pulse_cycles(input logic [LEN_W-1:0] l);
    return CNT_W'(1) << (CNT_W'(l) + CNT_W'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (trigger)        cnt <= pulse_cycles(len);
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign ext_rst_n = (cnt == '0);

  // R9: every trigger reloads the full programmed length
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (cnt == pulse_cycles($past(len))));

  // R5: without a trigger the count falls by exactly one per cycle
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/keyed_rst_mode.sv
module keyed_rst_mode
  import keyed_rst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wp_en,
  input  logic              pin_n,
  output logic              ext_rst_n,
  output logic              irq
);
  logic             pin_sync_n;
  logic             pin_low;
  logic             ursten;
  logic             urstien;
  logic [LEN_W-1:0] len;
  logic             hit_mode;
  logic             hit_stat;
  logic             mode_wr;
  logic             stat_rd;
  logic             trigger;
  logic             usr_flag;

  assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STATUS));
  assign mode_wr  = bus_sel && bus_wr && hit_mode;
  assign stat_rd  = bus_sel && !bus_wr && hit_stat;

  krm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_sync_n)
  );

  assign pin_low = !pin_sync_n;
  assign trigger = pin_low && ursten;

  krm_mode_reg #(.LEN_W(LEN_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_stb(mode_wr), .wdata(bus_wdata),
    .wp_en(wp_en), .ursten(ursten), .urstien(urstien), .len(len)
  );

  krm_pulse #(.LEN_W(LEN_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .len(len), .ext_rst_n(ext_rst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       usr_flag <= 1'b0;
    else if (pin_low) usr_flag <= 1'b1;
    else if (stat_rd) usr_flag <= 1'b0;
  end

  assign irq = usr_flag && urstien && !ursten;

  always_comb begin
    bus_rdata = '0;
    if (hit_mode) begin
      bus_rdata[BIT_EN]  = ursten;
      bus_rdata[BIT_IEN] = urstien;
      bus_rdata[LEN_LSB +: LEN_W] = len;
    end else if (hit_stat) begin
      bus_rdata[0] = usr_flag;
    end
  end

  // R8: the interrupt never fires while user reset is enabled
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!ursten && usr_flag));

  // R7: a status read with no new pin event clears the flag
  p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !pin_low) |=> !usr_flag);

  // R6: with user reset disabled the output stays high
  p_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ursten && $past(!ursten) && ext_rst_n) |=> ext_rst_n);
endmodule

// File: tb/sim_keyed_rst_mode.sv
module sim_keyed_rst_mode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wp_en = 1'b0, pin_n = 1'b1;
  logic ext_rst_n, irq;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  keyed_rst_mode u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wp_en(wp_en), .pin_n(pin_n), .ext_rst_n(ext_rst_n), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      $display("FAIL timeout actual=%0d expected=<190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Low for hold_cycles rising edges, then measure the ext_rst_n low phase.
  task automatic pin_event(input int hold_cycles, input logic exp_held, output int lows);
    @(negedge clk);
    pin_n = 1'b0;
    repeat (hold_cycles) @(negedge clk);
    pin_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ext_rst_n !== !exp_held) begin
      errors++;
      $display("FAIL R5 start timing actual=%b expected=%b", ext_rst_n, !exp_held);
    end
    lows = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk);
      if (ext_rst_n) break;
      lows++;
    end
  endtask

  initial begin
    logic [31:0] rd;
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(8'h08, rd); check("R1 mode", rd, 32'h1);
    bus_read(8'h04, rd); check("R1 status", rd, 32'h0);
    check("R1 ext_rst_n", {31'b0, ext_rst_n}, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R4 reserved bits
    bus_write(32'hA5FF_FFFF);
    bus_read(8'h08, rd); check("R4 writable mask", rd, 32'h0000_0F11);
    // R2 bad key ignored
    bus_write(32'h5A00_0000);
    bus_read(8'h08, rd); check("R2 bad key", rd, 32'h0000_0F11);
    bus_write(32'hA400_0200);
    bus_read(8'h08, rd); check("R2 near key", rd, 32'h0000_0F11);
    // R3 write protect
    wp_en = 1'b1;
    bus_write(32'hA500_0000);
    bus_read(8'h08, rd); check("R3 protected", rd, 32'h0000_0F11);
    wp_en = 1'b0;
    bus_write(32'hA500_0000);
    bus_read(8'h08, rd); check("R3 unprotected", rd, 32'h0);

    // R6 no pulse when disabled, R7 flag still set
    pin_event(1, 1'b0, lows);
    check("R6 no pulse", lows, 0);
    bus_read(8'h04, rd); check("R7 flag set", rd, 32'h1);
    bus_read(8'h04, rd); check("R7 flag cleared", rd, 32'h0);

    // R5 length sweep over every L
    for (int l = 0; l < 16; l++) begin
      bus_write(32'hA500_0001 | (32'(l) << 8));
      pin_event(1, 1'b0, lows);
      check($sformatf("R5 length L=%0d", l), lows, 32'(1) << (l + 1));
      bus_read(8'h04, rd); check("R7 flag after pulse", rd, 32'h1);
    end

    // R9 retrigger with L=2
    bus_write(32'hA500_0201);
    @(negedge clk); pin_n = 1'b0; @(negedge clk); pin_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 first pulse active", {31'b0, ext_rst_n}, 32'h0);
    pin_event(1, 1'b1, lows);
    check("R9 retrigger length", lows, 8);
    // R9 pin held low with L=0
    bus_write(32'hA500_0001);
    pin_event(10, 1'b1, lows);
    check("R9 held pin", lows, 2);
    bus_read(8'h04, rd);

    // R8 irq over all enable combinations
    for (int c = 0; c < 4; c++) begin
      bus_write(32'hA500_0000 | 32'(c[0]) | (32'(c[1]) << 4));
      pin_event(1, 1'b0, lows);
      check($sformatf("R8 irq en=%0d ien=%0d", c[0], c[1]), {31'b0, irq},
            {31'b0, (c[1] == 1'b1) && (c[0] == 1'b0)});
      bus_read(8'h04, rd);
      @(negedge clk);
      check("R8 irq after clear", {31'b0, irq}, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule